// File: doc/BRIEF.md
# SDRAM Command Spacing Monitor

This block watches the decoded command stream that a DDR SDRAM controller sends to the memory: one command per clock, with its bank and its auto-precharge / all-banks bit. It keeps cycle counters for each bank and for the device as a whole. From these it checks every command against the minimum spacings the memory needs: activate to column access, precharge to activate, activate to precharge, activate to activate on the same bank and on different banks, refresh recovery, mode-register lockout, write-with-auto-precharge recovery, and write-to-read turnaround.

The block only observes. It never holds the controller back. When a command breaks a rule, it raises a one-cycle violation flag together with a code that names the broken rule. All minimums are parameters counted in clock cycles. The defaults assume a 6 ns clock and a burst length of 4.

Command encoding on `cmd`: 0 = no operation, 1 = activate, 2 = read, 3 = write, 4 = precharge, 5 = refresh, 6 = mode-register set. The value 7 is reserved and is treated exactly like 0. The spacing between two commands is the difference of their issue cycles. Back-to-back commands have a spacing of 1.

Top module: `sdram_cmd_timing_mon`

## Requirements
- R1: Any command (codes 1 to 6) issued fewer than 2 cycles after a mode-register set is flagged with code 1.
- R2: Any command (codes 1 to 6) issued fewer than 12 cycles after a refresh is flagged with code 2.
- R3: A read or write issued to a bank fewer than 3 cycles after an activate of that bank is flagged with code 3.
- R4: An activate issued to a bank fewer than 3 cycles after a precharge is flagged with code 4. The precharge counts if it addressed that bank, or if `ap`=1, which means all banks.
- R5: A precharge is flagged with code 5 if it comes fewer than 7 cycles after the last activate of any bank it closes. A single-bank precharge closes its own bank. A precharge with `ap`=1 closes every bank.
- R6: An activate issued to a bank fewer than 10 cycles after the previous activate of the same bank is flagged with code 6.
- R7: An activate issued to a bank other than the most recently activated one, fewer than 2 cycles after that activate, is flagged with code 7.
- R8: After a write with `ap`=1 to a bank, an activate of that bank with a spacing below 9 is flagged with code 8. The 9 cycles are a burst end of BL/2+1 = 3 cycles plus 3 cycles of write recovery plus 3 cycles of precharge. Other banks are not affected by this rule.
- R9: A read to any bank issued fewer than 4 cycles after any write is flagged with code 9. The 4 cycles are a burst end of 3 plus 1 cycle of turnaround.
- R10: The result for a command sampled at clock edge k is driven from edge k until edge k+1. `viol` is high exactly when `viol_code` is non-zero. When several rules are broken at once, the lowest code is reported. Code 0 means no rule was broken.
- R11: After reset `viol` is 0, `viol_code` is 0 and every rule counts as satisfied. Codes 0 and 7 are never flagged and change no counter.
- R12: A command that breaks a rule still restarts the counters it would restart if it were legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Command code (see encoding above) |
| bank | input | BANK_W (2) | Bank addressed by the command |
| ap | input | 1 | Auto-precharge on write; all banks on precharge |
| viol | output | 1 | Violation flag for the command of the previous edge |
| viol_code | output | 4 | Lowest broken rule code, 0 when none |

## Verification
Every verdict is registered once, so the result for a command driven before edge k is read one time unit after edge k. Each command in the bench is issued at a falling edge and checked right after the following rising edge, so each check lines up with exactly one command. Each rule is swept over spacings from 1 up to one past its limit, starting from a fresh reset. The expected code is `gap < limit ? code : 0`, so both sides of every threshold are checked. The priority order and the recording of a violating command are checked with short sequences built by hand.

// File: rtl/sdram_cmd_timing_mon.sv
module sdram_cmd_timing_mon #(
  parameter int BANKS  = 4,
  parameter int BL     = 4,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 7,
  parameter int T_RC   = 10,
  parameter int T_RRD  = 2,
  parameter int T_RFC  = 12,
  parameter int T_MRD  = 2,
  parameter int T_WR   = 3,
  parameter int T_WTR  = 1,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic              ap,
  output logic              viol,
  output logic [3:0]        viol_code
);

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WEND    = BL / 2 + 1;
  localparam int DAL_GAP = WEND + T_WR + T_RP;
  localparam int WTR_GAP = WEND + T_WTR;
  localparam int MAXT    = imax(imax(imax(T_RCD, T_RP), imax(T_RAS, T_RC)),
                                imax(imax(T_RRD, T_RFC), imax(T_MRD, imax(DAL_GAP, WTR_GAP))));
  localparam int CW      = $clog2(MAXT + 1);

  localparam logic [CW-1:0] SAT   = CW'(MAXT);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] L_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC);
  localparam logic [CW-1:0] L_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] L_RFC = CW'(T_RFC);
  localparam logic [CW-1:0] L_MRD = CW'(T_MRD);
  localparam logic [CW-1:0] L_DAL = CW'(DAL_GAP);
  localparam logic [CW-1:0] L_WTR = CW'(WTR_GAP);

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_RSV = 3'd7;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return (c >= SAT) ? SAT : c + ONE;
  endfunction

  logic [CW-1:0] act_cnt [BANKS];
  logic [CW-1:0] pre_cnt [BANKS];
  logic [CW-1:0] wap_cnt [BANKS];
  logic [CW-1:0] mrs_cnt, ref_cnt, any_act_cnt, wr_cnt;
  logic [BANK_W-1:0] last_act_bank;
  logic [BANKS-1:0]  ras_bad;
  logic [9:1]        bad;
  logic [3:0]        code;

  wire is_cmd = (cmd != C_NOP) && (cmd != C_RSV);
  wire is_act = (cmd == C_ACT);
  wire is_col = (cmd == C_RD) || (cmd == C_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++) begin
        act_cnt[b] <= SAT;
        pre_cnt[b] <= SAT;
        wap_cnt[b] <= SAT;
      end
      mrs_cnt       <= SAT;
      ref_cnt       <= SAT;
      any_act_cnt   <= SAT;
      wr_cnt        <= SAT;
      last_act_bank <= '0;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        act_cnt[b] <= (is_act && bank == BANK_W'(b)) ? ONE : bump(act_cnt[b]);
        pre_cnt[b] <= (cmd == C_PRE && (ap || bank == BANK_W'(b))) ? ONE : bump(pre_cnt[b]);
        wap_cnt[b] <= (cmd == C_WR && ap && bank == BANK_W'(b)) ? ONE : bump(wap_cnt[b]);
      end
      mrs_cnt     <= (cmd == C_MRS) ? ONE : bump(mrs_cnt);
      ref_cnt     <= (cmd == C_REF) ? ONE : bump(ref_cnt);
      any_act_cnt <= is_act ? ONE : bump(any_act_cnt);
      wr_cnt      <= (cmd == C_WR) ? ONE : bump(wr_cnt);
      if (is_act) last_act_bank <= bank;
    end
  end

  always_comb begin
    for (int b = 0; b < BANKS; b++)
      ras_bad[b] = (cmd == C_PRE) && (ap || bank == BANK_W'(b)) && (act_cnt[b] < L_RAS);
  end

  assign bad[1] = is_cmd && (mrs_cnt < L_MRD);
  assign bad[2] = is_cmd && (ref_cnt < L_RFC);
  assign bad[3] = is_col && (act_cnt[bank] < L_RCD);
  assign bad[4] = is_act && (pre_cnt[bank] < L_RP);
  assign bad[5] = |ras_bad;
  assign bad[6] = is_act && (act_cnt[bank] < L_RC);
  assign bad[7] = is_act && (bank != last_act_bank) && (any_act_cnt < L_RRD);
  assign bad[8] = is_act && (wap_cnt[bank] < L_DAL);
  assign bad[9] = (cmd == C_RD) && (wr_cnt < L_WTR);

  always_comb begin
    code = 4'd0;
    for (int i = 9; i >= 1; i--)
      if (bad[i]) code = 4'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= 4'd0;
    end else begin
      viol      <= |bad;
      viol_code <= code;
    end
  end

endmodule

module sdram_cmd_timing_mon_chk #(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [BANK_W-1:0] bank,
  input logic              ap,
  input logic              viol,
  input logic [3:0]        viol_code
);

  // R10
  flag_code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol == (viol_code != 4'd0));

  // R11
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd0 || cmd == 3'd7) |=> !viol);

  // R1
  mrs_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd6) ##1 (cmd != 3'd0 && cmd != 3'd7) |=> (viol && viol_code == 4'd1));

  // R2
  ref_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd5) ##1 (cmd != 3'd0 && cmd != 3'd7) |=> (viol && viol_code <= 4'd2));

  // R3
  act_to_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) ##1 ((cmd == 3'd2 || cmd == 3'd3) && $stable(bank)) |=> viol);

  // R7
  act_other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) ##1 (cmd == 3'd1 && !$stable(bank)) |=> viol);

  // R6
  act_same_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd1) ##1 (cmd == 3'd1 && $stable(bank)) |=> viol);

endmodule

bind sdram_cmd_timing_mon sdram_cmd_timing_mon_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .ap(ap),
  .viol(viol), .viol_code(viol_code)
);

// File: tb/sdram_cmd_timing_mon_tb.sv
module sdram_cmd_timing_mon_tb;

  localparam int LIM_MRD = 2, LIM_RFC = 12, LIM_RCD = 3, LIM_RP = 3, LIM_RAS = 7;
  localparam int LIM_RC = 10, LIM_RRD = 2, LIM_DAL = 2 + 1 + 3 + 3, LIM_WTR = 2 + 1 + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic       ap = 1'b0;
  logic       viol;
  logic [3:0] viol_code;

  int runs = 0;
  int fails = 0;
  int cycles = 0;

  sdram_cmd_timing_mon u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .ap(ap),
    .viol(viol), .viol_code(viol_code)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cycles++;

  task automatic check(input string req, input int exp);
    runs++;
    if (viol !== (exp != 0) || viol_code !== 4'(exp)) begin
      fails++;
      $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d",
               req, viol, viol_code, exp != 0, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] c, input logic [1:0] b, input logic a,
                     input bit chk, input string req, input int exp);
    @(negedge clk);
    cmd = c; bank = b; ap = a;
    @(posedge clk);
    #1;
    if (chk) check(req, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(3'd0, 2'd0, 1'b0, 1'b0, "", 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd = 3'd0; bank = 2'd0; ap = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pair(input logic [2:0] c1, input logic [1:0] b1, input logic a1,
                      input logic [2:0] c2, input logic [1:0] b2, input logic a2,
                      input int gap, input string req, input int exp);
    do_reset();
    cyc(c1, b1, a1, 1'b0, "", 0);
    idle(gap - 1);
    cyc(c2, b2, a2, 1'b1, req, exp);
  endtask

  initial begin
    do_reset();
    #1;
    check("R11 reset", 0);

    for (int g = 1; g <= LIM_MRD + 1; g++)
      pair(3'd6, 0, 0, 3'd1, 0, 0, g, "R1 mrs", (g < LIM_MRD) ? 1 : 0);
    for (int g = 1; g <= LIM_RFC + 1; g++)
      pair(3'd5, 0, 0, 3'd1, 0, 0, g, "R2 ref", (g < LIM_RFC) ? 2 : 0);
    for (int g = 1; g <= LIM_RCD + 1; g++) begin
      pair(3'd1, 1, 0, 3'd2, 1, 0, g, "R3 rd", (g < LIM_RCD) ? 3 : 0);
      pair(3'd1, 1, 0, 3'd3, 1, 0, g, "R3 wr", (g < LIM_RCD) ? 3 : 0);
    end
    for (int g = 1; g <= LIM_RP + 1; g++) begin
      pair(3'd4, 1, 0, 3'd1, 1, 0, g, "R4 pre", (g < LIM_RP) ? 4 : 0);
      pair(3'd4, 0, 1, 3'd1, 2, 0, g, "R4 pre_all", (g < LIM_RP) ? 4 : 0);
    end
    pair(3'd4, 0, 0, 3'd1, 1, 0, 1, "R4 other bank", 0);
    for (int g = 1; g <= LIM_RAS + 1; g++) begin
      pair(3'd1, 2, 0, 3'd4, 2, 0, g, "R5 pre", (g < LIM_RAS) ? 5 : 0);
      pair(3'd1, 3, 0, 3'd4, 0, 1, g, "R5 pre_all", (g < LIM_RAS) ? 5 : 0);
    end
    pair(3'd1, 3, 0, 3'd4, 0, 0, 1, "R5 other bank", 0);
    for (int g = 1; g <= LIM_RC + 1; g++)
      pair(3'd1, 0, 0, 3'd1, 0, 0, g, "R6 rc", (g < LIM_RC) ? 6 : 0);
    for (int g = 1; g <= LIM_RRD + 1; g++)
      pair(3'd1, 0, 0, 3'd1, 1, 0, g, "R7 rrd", (g < LIM_RRD) ? 7 : 0);
    for (int g = 1; g <= LIM_DAL + 1; g++)
      pair(3'd3, 0, 1, 3'd1, 0, 0, g, "R8 dal", (g < LIM_DAL) ? 8 : 0);
    pair(3'd3, 0, 1, 3'd1, 1, 0, 2, "R8 other bank", 0);
    pair(3'd3, 0, 0, 3'd1, 0, 0, 2, "R8 no ap", 0);
    for (int g = 1; g <= LIM_WTR + 1; g++)
      pair(3'd3, 0, 0, 3'd2, 1, 0, g, "R9 wtr", (g < LIM_WTR) ? 9 : 0);

    // R10 priority: refresh (2) and same-bank activate (6) together
    do_reset();
    cyc(3'd1, 0, 0, 1'b1, "R10 first", 0);
    cyc(3'd5, 0, 0, 1'b1, "R10 ref", 0);
    cyc(3'd1, 0, 0, 1'b1, "R10 priority", 2);
    cyc(3'd0, 0, 0, 1'b1, "R10 one cycle", 0);

    // R11 idle and reserved codes neither flag nor restart counters
    do_reset();
    cyc(3'd6, 0, 0, 1'b0, "", 0);
    cyc(3'd0, 0, 0, 1'b1, "R11 nop", 0);
    do_reset();
    cyc(3'd6, 0, 0, 1'b0, "", 0);
    cyc(3'd7, 0, 0, 1'b1, "R11 reserved", 0);
    cyc(3'd1, 0, 0, 1'b1, "R11 reserved no restart", 0);

    // R12 violating activate still restarts the same-bank counter
    do_reset();
    cyc(3'd1, 0, 0, 1'b0, "", 0);
    cyc(3'd1, 0, 0, 1'b1, "R12 violating", 6);
    idle(LIM_RC - 2);
    cyc(3'd1, 0, 0, 1'b1, "R12 restarted", 6);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    runs++;
    $display("FAIL watchdog: cycles=%0d expected completion", cycles);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule